// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block holds a small set of recently used virtual-to-physical page mappings. Each slot is tagged with a virtual page number and keeps the complete page table entry: the physical frame number and the protection bits. A lookup presents a full virtual address. All slot tags are compared at once, and on a hit the block returns the physical address and the protection bits combinationally, in the same cycle as the request.

On a miss the block only raises a miss flag. An outside agent, either a hardware table walker or a software handler, finds the mapping and writes it in through the fill port. A full buffer chooses a victim with a not-last-used rule. Maintenance inputs remove a single mapping by virtual page number, for example when its protection changes, or empty the whole buffer, for example on a process switch.

Top module: `tlb_fa`

## Requirements
- R1: A lookup whose page number matches a valid slot raises `lkp_hit_o` in the same cycle. `lkp_prot_o` then carries the stored protection bits.
- R2: A lookup with no matching valid slot raises `lkp_miss_o` and not `lkp_hit_o`. When `lkp_valid_i` is low, both flags stay low.
- R3: A fill of a page number that is not present writes the lowest-index invalid slot. The new mapping hits from the next cycle on, and no other valid slot is disturbed.
- R4: A fill of a page number that is already present overwrites that slot. The page number therefore never occupies two slots, and a single invalidate removes it completely.
- R5: An invalidate removes only the slot whose tag matches `inval_vpn_i`. An invalidate of a page number that is not present has no effect.
- R6: `flush_i` clears every slot. From the next cycle on, every lookup misses.
- R7: A lookup in the same cycle as `flush_i` reports a miss, even if the page number is cached.
- R8: A lookup hit makes its slot the most recently used one, and reset sets slot 0 as most recently used. A fill into a full buffer evicts the lowest-index slot that is not the most recently used one.
- R9: After reset, every slot is invalid and every lookup misses.
- R10: A fill in the same cycle as `flush_i` is dropped.
- R11: The physical address is the slot's frame number (bits 31:12) concatenated with the unchanged 12-bit page offset of the lookup address (bits 11:0). The virtual page number is taken from bits 31:12 of `lkp_vaddr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_vaddr_i | input | 32 | Lookup virtual address (page number 31:12, offset 11:0) |
| lkp_hit_o | output | 1 | Lookup hit, same cycle |
| lkp_miss_o | output | 1 | Lookup miss, same cycle |
| lkp_paddr_o | output | 32 | Physical address on hit, zero otherwise |
| lkp_prot_o | output | 3 | Protection bits on hit, zero otherwise |
| fill_valid_i | input | 1 | Write a mapping |
| fill_vpn_i | input | 20 | Virtual page number to write |
| fill_pfn_i | input | 20 | Physical frame number to write |
| fill_prot_i | input | 3 | Protection bits to write |
| inval_valid_i | input | 1 | Remove one mapping |
| inval_vpn_i | input | 20 | Virtual page number to remove |
| flush_i | input | 1 | Remove all mappings |

## Verification
A wrong valid bit or tag shows up at once as a wrong hit or miss flag on the next lookup of that page. A lost or duplicated entry only shows after an invalidate or an eviction, so the tests follow those operations with lookups of the neighbouring pages. A wrong recency index shows only when a fill hits a full buffer. The bench therefore fills every slot, steers the recency index with chosen hits, and then checks exactly which old page misses one cycle after the fill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VPN_W  = 20;
  localparam int PFN_W  = 20;
  localparam int OFF_W  = 12;
  localparam int PROT_W = 3;
  localparam int VA_W   = VPN_W + OFF_W;
  localparam int PA_W   = PFN_W + OFF_W;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N = 32,
  parameter int W = 20
) (
  input  logic [N-1:0][W-1:0] tags_i,
  input  logic [N-1:0]        valid_i,
  input  logic [W-1:0]        key_i,
  output logic [N-1:0]        match_o
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match_o[i] = valid_i[i] && (tags_i[i] == key_i);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N  = 32,
  parameter int IW = 5
) (
  input  logic [N-1:0]  valid_i,
  input  logic [IW-1:0] mru_i,
  output logic [IW-1:0] idx_o
);
  logic free_found;

  always_comb begin
    free_found = 1'b0;
    idx_o      = '0;
    // first invalid slot, lowest index wins
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        idx_o      = IW'(i);
        free_found = 1'b1;
      end
    end
    // full: lowest index that is not most recently used
    if (!free_found) begin
      for (int i = N - 1; i >= 0; i--) begin
        if (IW'(i) != mru_i) idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkp_valid_i,
  input  logic [VA_W-1:0]   lkp_vaddr_i,
  output logic              lkp_hit_o,
  output logic              lkp_miss_o,
  output logic [PA_W-1:0]   lkp_paddr_o,
  output logic [PROT_W-1:0] lkp_prot_o,
  input  logic              fill_valid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic [PROT_W-1:0] fill_prot_i,
  input  logic              inval_valid_i,
  input  logic [VPN_W-1:0]  inval_vpn_i,
  input  logic              flush_i
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0][VPN_W-1:0]  tag_q;
  logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q;
  logic [ENTRIES-1:0][PROT_W-1:0] prot_q;
  logic [ENTRIES-1:0]             valid_q;
  logic [IDX_W-1:0]               mru_q;

  logic [ENTRIES-1:0] lkp_match, fill_match, inval_match;
  logic [IDX_W-1:0]   lkp_idx, fill_hit_idx, inval_idx, victim_idx, fill_idx;
  logic               lkp_any, fill_any, inval_any;
  logic [PFN_W-1:0]   hit_pfn;
  logic [PROT_W-1:0]  hit_prot;

  tlb_cam #(.N(ENTRIES), .W(VPN_W)) u_cam_lkp (
    .tags_i(tag_q), .valid_i(valid_q), .key_i(lkp_vaddr_i[VA_W-1:OFF_W]), .match_o(lkp_match)
  );
  tlb_cam #(.N(ENTRIES), .W(VPN_W)) u_cam_fill (
    .tags_i(tag_q), .valid_i(valid_q), .key_i(fill_vpn_i), .match_o(fill_match)
  );
  tlb_cam #(.N(ENTRIES), .W(VPN_W)) u_cam_inval (
    .tags_i(tag_q), .valid_i(valid_q), .key_i(inval_vpn_i), .match_o(inval_match)
  );

  tlb_victim #(.N(ENTRIES), .IW(IDX_W)) u_victim (
    .valid_i(valid_q), .mru_i(mru_q), .idx_o(victim_idx)
  );

  // match vectors are one-hot or zero, so OR-encoding is exact
  always_comb begin
    lkp_idx      = '0;
    fill_hit_idx = '0;
    inval_idx    = '0;
    hit_pfn      = '0;
    hit_prot     = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lkp_match[i]) begin
        lkp_idx  = lkp_idx | IDX_W'(i);
        hit_pfn  = hit_pfn | pfn_q[i];
        hit_prot = hit_prot | prot_q[i];
      end
      if (fill_match[i])  fill_hit_idx = fill_hit_idx | IDX_W'(i);
      if (inval_match[i]) inval_idx    = inval_idx | IDX_W'(i);
    end
  end

  assign lkp_any   = |lkp_match;
  assign fill_any  = |fill_match;
  assign inval_any = |inval_match;
  assign fill_idx  = fill_any ? fill_hit_idx : victim_idx;

  assign lkp_hit_o   = lkp_valid_i && !flush_i && lkp_any;
  assign lkp_miss_o  = lkp_valid_i && !lkp_hit_o;
  assign lkp_paddr_o = lkp_hit_o ? {hit_pfn, lkp_vaddr_i[OFF_W-1:0]} : '0;
  assign lkp_prot_o  = lkp_hit_o ? hit_prot : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      mru_q   <= '0;
      tag_q   <= '0;
      pfn_q   <= '0;
      prot_q  <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
    end else begin
      if (inval_valid_i && inval_any) valid_q[inval_idx] <= 1'b0;
      // fill after invalidate: fill wins on the same slot
      if (fill_valid_i) begin
        valid_q[fill_idx] <= 1'b1;
        tag_q[fill_idx]   <= fill_vpn_i;
        pfn_q[fill_idx]   <= fill_pfn_i;
        prot_q[fill_idx]  <= fill_prot_i;
      end
      if (lkp_hit_o) mru_q <= lkp_idx;
    end
  end

  AST_HIT_MISS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lkp_hit_o && lkp_miss_o)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_valid_i |-> (!lkp_hit_o && !lkp_miss_o)); // R2
  AST_UNIQUE_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fill_match) && $onehot0(lkp_match)); // R4
  AST_FLUSH_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !lkp_hit_o); // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0)); // R6
  AST_FILL_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !flush_i) |=> valid_q[$past(fill_idx)]); // R3
  AST_VICTIM_NOT_MRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&valid_q) |-> (victim_idx != mru_q)); // R8
endmodule

// File: tb/tb_tlb_fa.sv
`timescale 1ns/1ps
module tb_tlb_fa;
  localparam int N = 32;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lkp_valid_i = 1'b0;
  logic [31:0] lkp_vaddr_i = '0;
  logic        lkp_hit_o, lkp_miss_o;
  logic [31:0] lkp_paddr_o;
  logic [2:0]  lkp_prot_o;
  logic        fill_valid_i = 1'b0;
  logic [19:0] fill_vpn_i = '0, fill_pfn_i = '0;
  logic [2:0]  fill_prot_i = '0;
  logic        inval_valid_i = 1'b0;
  logic [19:0] inval_vpn_i = '0;
  logic        flush_i = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  logic r_hit, r_miss;
  logic [31:0] r_paddr;
  logic [2:0]  r_prot;

  always #2.5 clk_i = ~clk_i;

  tlb_fa #(.ENTRIES(N)) dut (.*);

  function automatic logic [19:0] vpn_a(int i); return 20'h40000 + 20'(i); endfunction
  function automatic logic [19:0] pfn_a(int i); return 20'h00100 + 20'(i); endfunction
  function automatic logic [2:0]  prot_a(int i); return 3'(i % 8); endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic look(logic [19:0] vpn, logic [11:0] off, logic with_flush = 1'b0);
    lkp_valid_i = 1'b1;
    lkp_vaddr_i = {vpn, off};
    flush_i     = with_flush;
    #1;
    r_hit = lkp_hit_o; r_miss = lkp_miss_o; r_paddr = lkp_paddr_o; r_prot = lkp_prot_o;
    @(negedge clk_i);
    lkp_valid_i = 1'b0;
    flush_i     = 1'b0;
  endtask

  task automatic fill(logic [19:0] vpn, logic [19:0] pfn, logic [2:0] prot, logic with_flush = 1'b0);
    fill_valid_i = 1'b1; fill_vpn_i = vpn; fill_pfn_i = pfn; fill_prot_i = prot;
    flush_i = with_flush;
    @(negedge clk_i);
    fill_valid_i = 1'b0;
    flush_i = 1'b0;
  endtask

  task automatic inval(logic [19:0] vpn);
    inval_valid_i = 1'b1; inval_vpn_i = vpn;
    @(negedge clk_i);
    inval_valid_i = 1'b0;
  endtask

  task automatic expect_hit(string req, logic [19:0] vpn, logic [19:0] pfn, logic [2:0] prot, logic [11:0] off);
    look(vpn, off);
    check(req, {r_hit, r_miss}, 2'b10);
    check(req, r_paddr, {pfn, off});
    check(req, r_prot, prot);
  endtask

  task automatic expect_miss(string req, logic [19:0] vpn);
    look(vpn, 12'h0);
    check(req, {r_hit, r_miss, r_paddr}, {2'b01, 32'h0});
  endtask

  task automatic t_reset();
    lkp_valid_i = 1'b0; #1;
    check("R2 idle", {lkp_hit_o, lkp_miss_o}, 2'b00);
    expect_miss("R9 reset", vpn_a(0));
    expect_miss("R9 reset", vpn_a(31));
  endtask

  task automatic t_fill_all();
    for (int i = 0; i < N; i++) fill(vpn_a(i), pfn_a(i), prot_a(i));
    for (int i = 0; i < N; i++) expect_hit("R1 R11 fill_all", vpn_a(i), pfn_a(i), prot_a(i), 12'((i * 291) & 12'hfff));
    expect_miss("R2 absent", 20'h7beef);
  endtask

  task automatic t_replace();
    expect_hit("R8 mark", vpn_a(5), pfn_a(5), prot_a(5), 12'h5);
    fill(20'h50000, 20'hb0000, 3'd1);          // full, mru=5 -> slot 0
    expect_miss("R8 evict slot0", vpn_a(0));
    expect_hit("R8 new B", 20'h50000, 20'hb0000, 3'd1, 12'hfff); // mru=0
    fill(20'h50001, 20'hc0000, 3'd2);          // mru=0 -> slot 1
    expect_miss("R8 evict slot1", vpn_a(1));
    expect_hit("R8 new C", 20'h50001, 20'hc0000, 3'd2, 12'h001);
    expect_hit("R8 keep A2", vpn_a(2), pfn_a(2), prot_a(2), 12'h0);
    expect_hit("R8 keep B", 20'h50000, 20'hb0000, 3'd1, 12'h0);
  endtask

  task automatic t_inval();
    int bad;
    inval(vpn_a(7));
    expect_miss("R5 removed", vpn_a(7));
    expect_hit("R5 neighbour", vpn_a(8), pfn_a(8), prot_a(8), 12'h0);
    inval(20'hfffff);
    expect_hit("R5 absent no effect", vpn_a(9), pfn_a(9), prot_a(9), 12'h0);
    fill(20'h50002, 20'hd0000, 3'd3);          // first invalid = slot 7
    expect_hit("R3 free slot", 20'h50002, 20'hd0000, 3'd3, 12'h0);
    bad = 0;
    for (int i = 2; i < N; i++) begin
      if (i != 7) begin
        look(vpn_a(i), 12'h0);
        if (!(r_hit && r_paddr == {pfn_a(i), 12'h0})) bad++;
      end
    end
    check("R3 nothing evicted", bad, 0);
    expect_hit("R3 keep B", 20'h50000, 20'hb0000, 3'd1, 12'h0);
    expect_hit("R3 keep C", 20'h50001, 20'hc0000, 3'd2, 12'h0);
  endtask

  task automatic t_dup();
    fill(vpn_a(10), 20'habcde, 3'd5);
    expect_hit("R4 overwrite", vpn_a(10), 20'habcde, 3'd5, 12'h123);
    expect_hit("R4 keep B", 20'h50000, 20'hb0000, 3'd1, 12'h0);
    inval(vpn_a(10));
    expect_miss("R4 single copy", vpn_a(10));
  endtask

  task automatic t_flush();
    look(vpn_a(11), 12'h0, 1'b1);
    check("R7 flush lookup", {r_hit, r_miss}, 2'b01);
    expect_miss("R6 flushed A12", vpn_a(12));
    expect_miss("R6 flushed B", 20'h50000);
    expect_miss("R6 flushed A31", vpn_a(31));
    fill(20'h60000, 20'h12345, 3'd6, 1'b1);
    expect_miss("R10 fill dropped", 20'h60000);
    fill(20'h60001, 20'h23456, 3'd7);
    expect_hit("R3 after flush", 20'h60001, 20'h23456, 3'd7, 12'habc);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_fill_all();
    t_replace();
    t_inval();
    t_dup();
    t_flush();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule